// File: doc/BRIEF.md
# Delegated Interrupt Enable and Pending Registers

This block holds the machine-level interrupt enable word, the machine-level interrupt pending word and the delegation mask for the three supervisor interrupt classes: software, timer and external. A single CSR access port reaches all of them. It carries an address, read and write strobes, write data and combinational read data. Two extra addresses give supervisor-level windows onto the same storage. These windows hold no bits of their own. Each field in them is gated by its delegation bit, so a supervisor access only sees and changes interrupts that have been handed down.

The write rights differ between the two windows. Through the enable window, every delegated enable bit can be written. Through the pending window, only the software pending bit can be written. Timer and external pending follow level inputs from an outside interrupt controller. That controller can also raise the software pending bit with a one-cycle set pulse.

Top module: `irq_view_csr`

## Requirements
- R1: After reset, every readable word (0x304, 0x303, 0x344, 0x104, 0x144) reads as zero.
- R2: A write to 0x304 stores bits 1, 3, 5, 7, 9 and 11 of the write data as the machine enable word; all other bits of that word read zero.
- R3: A write to 0x303 stores only bits 1 (software), 5 (timer) and 9 (external) of the delegation mask; every other mask bit reads zero.
- R4: A read of 0x104 returns enable bits 1, 5 and 9 only where the matching delegation bit is set; all other bits read zero.
- R5: A write to 0x104 changes enable bit 1, 5 or 9 only when that class is delegated; undelegated bits and machine bits 3, 7, 11 keep their value.
- R6: A read of 0x144 returns pending bits 1, 5 and 9 only where the matching delegation bit is set; all other bits read zero.
- R7: A write to 0x144 changes only pending bit 1, and only when the software class is delegated; bits 5 and 9 are unaffected by it.
- R8: Pending bits 5 (timer) and 9 (external) equal the level of their input as sampled at the most recent clock edge; no CSR write changes them.
- R9: A set pulse on the software-pending input makes bit 1 of the pending word 1 after the edge, even when a write clearing that bit occurs in the same cycle.
- R10: A write to 0x344 stores bit 1 of the write data as software pending; all other pending bits, including machine bits 3, 7 and 11, read zero or follow their inputs.
- R11: Read data is combinational from the current state and is zero when the read strobe is low or the address is unmapped; a write becomes visible only after the next clock edge, and a write to an unmapped address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_addr | input | 12 | CSR address |
| csr_rd_en | input | 1 | Read strobe |
| csr_wr_en | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational |
| stimer_lvl | input | 1 | Supervisor timer pending level from the interrupt controller |
| sext_lvl | input | 1 | Supervisor external pending level from the interrupt controller |
| ssoft_set | input | 1 | One-cycle set request for supervisor software pending |

## Verification
The bench builds the block with XLEN set to 32 and keeps the default addresses. The narrower word lets all-ones write patterns reach every upper bit, which shows that only the architected positions can be stored. Delegation is changed between single classes and all classes. This reaches the gating of each window bit by bit, in both the read direction and the write direction. The race between a software clear and a controller set on the software pending bit is driven in one cycle.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

  // Number of delegable interrupt classes: software, timer, external
  localparam int unsigned N_CLASS = 3;

  // Supervisor bit of class k sits at 4k+1, machine bit at 4k+3
  function automatic int unsigned sup_bit(input int unsigned k);
    return 4 * k + 1;
  endfunction

  function automatic int unsigned mach_bit(input int unsigned k);
    return 4 * k + 3;
  endfunction

  // Which CSR window an address selects
  typedef struct packed {
    logic m_en;
    logic m_pend;
    logic deleg;
    logic s_en;
    logic s_pend;
  } csr_sel_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_csr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter logic [11:0] ADDR_M_EN   = 12'h304,
  parameter logic [11:0] ADDR_M_PEND = 12'h344,
  parameter logic [11:0] ADDR_DELEG  = 12'h303,
  parameter logic [11:0] ADDR_S_EN   = 12'h104,
  parameter logic [11:0] ADDR_S_PEND = 12'h144
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_t          sel
);

  always_comb begin
    sel        = '0;
    sel.m_en   = (addr == ADDR_W'(ADDR_M_EN));
    sel.m_pend = (addr == ADDR_W'(ADDR_M_PEND));
    sel.deleg  = (addr == ADDR_W'(ADDR_DELEG));
    sel.s_en   = (addr == ADDR_W'(ADDR_S_EN));
    sel.s_pend = (addr == ADDR_W'(ADDR_S_PEND));
  end

endmodule

// File: rtl/irq_class_slice.sv
module irq_class_slice #(
  parameter bit IS_SOFT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_m_en,
  input  logic we_m_pend,
  input  logic we_deleg,
  input  logic we_s_en,
  input  logic we_s_pend,
  input  logic wd_sup,
  input  logic wd_mach,
  input  logic lvl_i,
  input  logic set_i,
  output logic deleg_o,
  output logic s_en_o,
  output logic m_en_o,
  output logic s_pend_o
);

  logic deleg_q, deleg_d, deleg_ce;
  logic s_en_q,  s_en_d,  s_en_ce;
  logic m_en_q,  m_en_d,  m_en_ce;
  logic s_pend_q, s_pend_d, s_pend_ce;

  // Next-state logic
  always_comb begin
    deleg_ce = we_deleg;
    deleg_d  = wd_sup;

    m_en_ce  = we_m_en;
    m_en_d   = wd_mach;

    // Supervisor enable shares storage between the two windows
    s_en_ce  = we_m_en | (we_s_en & deleg_q);
    s_en_d   = wd_sup;
  end

  generate
    if (IS_SOFT) begin : g_soft
      logic sw_wr;
      always_comb begin
        sw_wr     = we_m_pend | (we_s_pend & deleg_q);
        s_pend_ce = set_i | sw_wr;
        s_pend_d  = set_i ? 1'b1 : wd_sup;
      end
      logic unused_lvl;
      assign unused_lvl = lvl_i;
    end else begin : g_level
      always_comb begin
        s_pend_ce = 1'b1;
        s_pend_d  = lvl_i;
      end
      logic unused_wr;
      assign unused_wr = we_m_pend ^ we_s_pend ^ set_i;
    end
  endgenerate

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deleg_q  <= 1'b0;
      s_en_q   <= 1'b0;
      m_en_q   <= 1'b0;
      s_pend_q <= 1'b0;
    end else begin
      if (deleg_ce)  deleg_q  <= deleg_d;
      if (s_en_ce)   s_en_q   <= s_en_d;
      if (m_en_ce)   m_en_q   <= m_en_d;
      if (s_pend_ce) s_pend_q <= s_pend_d;
    end
  end

  assign deleg_o  = deleg_q;
  assign s_en_o   = s_en_q;
  assign m_en_o   = m_en_q;
  assign s_pend_o = s_pend_q;

  AST_UNDELEG_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (we_s_en && !deleg_q) |=> $stable(s_en_q)); // R5

  AST_MACH_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_m_en) |=> $stable(m_en_q)); // R5

  generate
    if (IS_SOFT) begin : g_chk_soft
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> s_pend_q); // R9
      AST_UNDELEG_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_s_pend && !deleg_q && !set_i) |=> $stable(s_pend_q)); // R7
    end else begin : g_chk_level
      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s_pend_q == $past(lvl_i))); // R8
    end
  endgenerate

endmodule

// File: rtl/irq_view_csr.sv
module irq_view_csr
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN        = 64,
  parameter logic [11:0] ADDR_M_EN   = 12'h304,
  parameter logic [11:0] ADDR_M_PEND = 12'h344,
  parameter logic [11:0] ADDR_DELEG  = 12'h303,
  parameter logic [11:0] ADDR_S_EN   = 12'h104,
  parameter logic [11:0] ADDR_S_PEND = 12'h144
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            csr_rd_en,
  input  logic            csr_wr_en,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            stimer_lvl,
  input  logic            sext_lvl,
  input  logic            ssoft_set
);

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned TOP_BIT = mach_bit(N_CLASS - 1);

  logic     rst_sync_n;
  csr_sel_t sel;
  csr_sel_t we;

  logic [N_CLASS-1:0] lvl_vec;
  logic [N_CLASS-1:0] set_vec;
  logic [N_CLASS-1:0] deleg_b, s_en_b, m_en_b, s_pend_b;

  logic [XLEN-1:0] sup_mask;
  logic [XLEN-1:0] m_en_word, m_pend_word, deleg_word;
  logic [XLEN-1:0] s_en_view, s_pend_view;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_csr_decode #(
    .ADDR_W      (ADDR_W),
    .ADDR_M_EN   (ADDR_M_EN),
    .ADDR_M_PEND (ADDR_M_PEND),
    .ADDR_DELEG  (ADDR_DELEG),
    .ADDR_S_EN   (ADDR_S_EN),
    .ADDR_S_PEND (ADDR_S_PEND)
  ) u_dec (
    .addr (csr_addr),
    .sel  (sel)
  );

  assign we = csr_wr_en ? sel : '0;

  // Class order: 0 software, 1 timer, 2 external
  assign lvl_vec = {sext_lvl, stimer_lvl, 1'b0};
  assign set_vec = {1'b0, 1'b0, ssoft_set};

  generate
    for (genvar k = 0; k < N_CLASS; k++) begin : g_cls
      irq_class_slice #(
        .IS_SOFT (k == 0)
      ) u_slice (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .we_m_en   (we.m_en),
        .we_m_pend (we.m_pend),
        .we_deleg  (we.deleg),
        .we_s_en   (we.s_en),
        .we_s_pend (we.s_pend),
        .wd_sup    (csr_wdata[sup_bit(k)]),
        .wd_mach   (csr_wdata[mach_bit(k)]),
        .lvl_i     (lvl_vec[k]),
        .set_i     (set_vec[k]),
        .deleg_o   (deleg_b[k]),
        .s_en_o    (s_en_b[k]),
        .m_en_o    (m_en_b[k]),
        .s_pend_o  (s_pend_b[k])
      );
    end
  endgenerate

  // Assemble the architectural words
  always_comb begin
    sup_mask    = '0;
    m_en_word   = '0;
    m_pend_word = '0;
    deleg_word  = '0;
    for (int k = 0; k < N_CLASS; k++) begin
      sup_mask[sup_bit(k)]    = 1'b1;
      m_en_word[sup_bit(k)]   = s_en_b[k];
      m_en_word[mach_bit(k)]  = m_en_b[k];
      m_pend_word[sup_bit(k)] = s_pend_b[k];
      deleg_word[sup_bit(k)]  = deleg_b[k];
    end
  end

  // Supervisor windows: no storage, gated per bit by delegation
  assign s_en_view   = m_en_word   & deleg_word;
  assign s_pend_view = m_pend_word & deleg_word;

  always_comb begin
    csr_rdata = '0;
    if (csr_rd_en) begin
      if (sel.m_en)   csr_rdata = m_en_word;
      if (sel.m_pend) csr_rdata = m_pend_word;
      if (sel.deleg)  csr_rdata = deleg_word;
      if (sel.s_en)   csr_rdata = s_en_view;
      if (sel.s_pend) csr_rdata = s_pend_view;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^csr_wdata;

  initial begin
    if (XLEN <= TOP_BIT) $error("XLEN too small for interrupt bit layout");
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !csr_rd_en |-> (csr_rdata == '0)); // R11

  AST_DELEG_ONLY_SUP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_rd_en && sel.deleg) |-> ((csr_rdata & ~sup_mask) == '0)); // R3

  AST_S_EN_VIEW_SUP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_rd_en && sel.s_en) |-> ((csr_rdata & ~sup_mask) == '0)); // R4

  AST_S_PEND_VIEW_SUP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_rd_en && sel.s_pend) |-> ((csr_rdata & ~sup_mask) == '0)); // R6

  AST_M_PEND_NO_MACH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_rd_en && sel.m_pend) |-> ((csr_rdata & ~sup_mask) == '0)); // R10

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(sel)); // R11

endmodule

// File: tb/sim_irq_view_csr.sv
`timescale 1ns/1ps
module sim_irq_view_csr;

  localparam int unsigned XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [11:0]     csr_addr;
  logic            csr_rd_en;
  logic            csr_wr_en;
  logic [XLEN-1:0] csr_wdata;
  logic [XLEN-1:0] csr_rdata;
  logic            stimer_lvl;
  logic            sext_lvl;
  logic            ssoft_set;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          done     = 1'b0;

  always #10 clk = ~clk;

  irq_view_csr #(.XLEN(XLEN)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_addr   (csr_addr),
    .csr_rd_en  (csr_rd_en),
    .csr_wr_en  (csr_wr_en),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .stimer_lvl (stimer_lvl),
    .sext_lvl   (sext_lvl),
    .ssoft_set  (ssoft_set)
  );

  localparam logic [11:0] A_MEN = 12'h304;
  localparam logic [11:0] A_MPD = 12'h344;
  localparam logic [11:0] A_DLG = 12'h303;
  localparam logic [11:0] A_SEN = 12'h104;
  localparam logic [11:0] A_SPD = 12'h144;

  task automatic check(input string req, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive a write in one cycle; effect visible after the next rising edge
  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_addr  = a;
    csr_wdata = d;
    csr_wr_en = 1'b1;
    @(negedge clk);
    csr_wr_en = 1'b0;
    csr_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a,
                          input logic [XLEN-1:0] exp);
    @(negedge clk);
    csr_addr  = a;
    csr_rd_en = 1'b1;
    #1;
    check(req, csr_rdata, exp);
    csr_rd_en = 1'b0;
  endtask

  task automatic t_reset();
    rd_check("R1 m_en",   A_MEN, 32'h0);
    rd_check("R1 deleg",  A_DLG, 32'h0);
    rd_check("R1 m_pend", A_MPD, 32'h0);
    rd_check("R1 s_en",   A_SEN, 32'h0);
    rd_check("R1 s_pend", A_SPD, 32'h0);
  endtask

  task automatic t_machine_enable();
    wr(A_MEN, 32'hFFFF_FFFF);
    rd_check("R2 m_en all ones", A_MEN, 32'h0000_0AAA);
    rd_check("R4 s_en undelegated", A_SEN, 32'h0);
  endtask

  task automatic t_deleg();
    wr(A_DLG, 32'hFFFF_FFFF);
    rd_check("R3 deleg mask", A_DLG, 32'h0000_0222);
    rd_check("R4 s_en all delegated", A_SEN, 32'h0000_0222);
    wr(A_DLG, 32'h0000_0020);
    rd_check("R4 s_en timer only", A_SEN, 32'h0000_0020);
  endtask

  task automatic t_s_en_write();
    wr(A_SEN, 32'h0);                       // deleg = timer only
    rd_check("R5 only timer cleared", A_MEN, 32'h0000_0A8A);
    wr(A_SEN, 32'hFFFF_FFFF);
    rd_check("R5 timer set again", A_MEN, 32'h0000_0AAA);
    wr(A_DLG, 32'h0);
    wr(A_SEN, 32'h0);
    rd_check("R5 undelegated write ignored", A_MEN, 32'h0000_0AAA);
  endtask

  task automatic t_levels();
    @(negedge clk);
    stimer_lvl = 1'b1;
    sext_lvl   = 1'b1;
    rd_check("R8 levels latched", A_MPD, 32'h0000_0220);
    wr(A_MPD, 32'h0);
    rd_check("R8 levels not writable", A_MPD, 32'h0000_0220);
    @(negedge clk);
    stimer_lvl = 1'b0;
    rd_check("R8 timer dropped", A_MPD, 32'h0000_0200);
    @(negedge clk);
    sext_lvl = 1'b0;
    rd_check("R8 external dropped", A_MPD, 32'h0);
  endtask

  task automatic t_m_pend_write();
    wr(A_MPD, 32'hFFFF_FFFF);
    rd_check("R10 only soft pending stored", A_MPD, 32'h0000_0002);
    wr(A_MPD, 32'h0);
    rd_check("R10 soft pending cleared", A_MPD, 32'h0);
  endtask

  task automatic t_s_pend();
    wr(A_DLG, 32'h0000_0200);
    @(negedge clk);
    sext_lvl = 1'b1;
    wr(A_MPD, 32'h0000_0002);
    rd_check("R6 m_pend both", A_MPD, 32'h0000_0202);
    rd_check("R6 s_pend external only", A_SPD, 32'h0000_0200);
    wr(A_SPD, 32'h0);
    rd_check("R7 undelegated soft kept", A_MPD, 32'h0000_0202);
    wr(A_DLG, 32'h0000_0222);
    rd_check("R6 s_pend all delegated", A_SPD, 32'h0000_0202);
    wr(A_SPD, 32'h0);
    rd_check("R7 delegated soft cleared", A_MPD, 32'h0000_0200);
    @(negedge clk);
    sext_lvl = 1'b0;
    wr(A_SPD, 32'h0000_0220);
    rd_check("R7 timer/ext not writable", A_MPD, 32'h0);
  endtask

  task automatic t_set_prio();
    @(negedge clk);
    ssoft_set = 1'b1;
    @(negedge clk);
    ssoft_set = 1'b0;
    rd_check("R9 set pulse", A_MPD, 32'h0000_0002);
    @(negedge clk);
    csr_addr  = A_SPD;
    csr_wdata = 32'h0;
    csr_wr_en = 1'b1;
    ssoft_set = 1'b1;
    @(negedge clk);
    csr_wr_en = 1'b0;
    ssoft_set = 1'b0;
    rd_check("R9 set beats clear", A_MPD, 32'h0000_0002);
    wr(A_SPD, 32'h0);
    rd_check("R9 clear without set", A_MPD, 32'h0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    csr_addr  = A_MEN;
    csr_rd_en = 1'b0;
    #1;
    check("R11 read strobe low", csr_rdata, 32'h0);
    rd_check("R11 unmapped read", 12'h305, 32'h0);
    wr(12'h305, 32'h0);
    rd_check("R11 unmapped write", A_MEN, 32'h0000_0AAA);
    @(negedge clk);
    csr_addr  = A_MEN;
    csr_wdata = 32'h0;
    csr_wr_en = 1'b1;
    csr_rd_en = 1'b1;
    #1;
    check("R11 old value before edge", csr_rdata, 32'h0000_0AAA);
    @(negedge clk);
    csr_wr_en = 1'b0;
    #1;
    check("R11 new value after edge", csr_rdata, 32'h0);
    csr_rd_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    csr_addr   = '0;
    csr_rd_en  = 1'b0;
    csr_wr_en  = 1'b0;
    csr_wdata  = '0;
    stimer_lvl = 1'b0;
    sext_lvl   = 1'b0;
    ssoft_set  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    t_reset();
    t_machine_enable();
    t_deleg();
    t_s_en_write();
    t_levels();
    t_m_pend_write();
    t_s_pend();
    t_set_prio();
    t_timing();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule